// File: doc/BRIEF.md
# LPDDR2 Power-Up Initialization Sequencer

This block takes one or two LPDDR2 ranks from power-on to normal operation without software involvement. After reset it switches on the PHY delay-locked loop and waits until the loop reports lock. It then sends a single resync strobe so the PHY takes up the new delay value. Throughout this phase it keeps CKE low. Next it runs the per-rank bring-up for each rank in turn. A NOP raises CKE, the sequencer waits out the long power-up interval, and an MRS resets the device and loads its operating parameters. After a short settle time it polls the device's auto-initialization (DAI) status with repeated MRR reads until the device reports that it is ready.

Every delay comes from a single down-counter. The counter is loaded with a cycle count that is derived at elaboration from the clock frequency and the interval in nanoseconds, as ceil(ns × MHz / 1000). Elaboration fails if the clock parameter is zero or above 50 MHz. A second counter bounds both the wait for lock and the DAI polling of each rank. When either limit runs out, the sequencer stops in an error state. Auto-refresh and power-down stay disabled until every configured rank has finished.

Top module: `lpddr_init_seq`

## Requirements
- R1: While `rst_n` is low: `cke`=0, `cmd`=00 (idle), and `dll_start`, `dll_resync`, `aref_en`, `pd_en`, `init_done` and `init_err` are all 0.
- R2: `dll_start` goes high within two cycles of reset release and stays high. Until the lock has been taken up, no command other than idle is issued and `cke` stays low.
- R3: `dll_resync` is high for exactly one cycle in the whole sequence. That cycle immediately follows the first cycle in which `dll_locked` is sampled high while `dll_start` is high. `cke` is still low in that cycle.
- R4: `cke` stays low from reset until the first NOP (`cmd`=01). That NOP comes exactly CKE_CYC+1 cycles after the resync cycle, where CKE_CYC = ceil(T_CKE_NS·CLK_MHZ/1000). `cke` is high in the NOP cycle and never falls afterwards. No command is issued while `cke` is low.
- R5: For each rank, the MRS (`cmd`=10) comes exactly INIT_CYC+1 cycles after that rank's NOP, where INIT_CYC = ceil(T_INIT_NS·CLK_MHZ/1000).
- R6: For each rank, the first MRR (`cmd`=11) comes exactly MRW_CYC+1 cycles after the MRS, where MRW_CYC = ceil(T_MRW_NS·CLK_MHZ/1000).
- R7: Every response with `mrr_valid`=1 and `mrr_dai_busy`=1 causes a new MRR in the next cycle. A rank is complete at its first response with `mrr_dai_busy`=0. Each rank therefore gets exactly (busy responses + 1) MRRs.
- R8: With `two_ranks`=1, rank 1 repeats the NOP, MRS and polling steps, and its NOP comes in the cycle after rank 0's final response. `rank_idx` is 0 for all rank 0 commands and 1 for all rank 1 commands. With `two_ranks`=0, only one NOP is issued and `rank_idx` stays 0.
- R9: `aref_en` and `pd_en` are low until `init_done` rises. `init_done` rises in the cycle after the last rank's final response, and both enables are high with it (PD_AFTER_INIT=1).
- R10: If `dll_locked` never rises, `init_err` rises within TMO_CYC+4 cycles of reset release. In that case `cke` never rises, no command is issued and `init_done` stays low.
- R11: If every DAI response is busy, `init_err` rises TMO_CYC or TMO_CYC+1 cycles after the rank's first MRR. No command is issued after that, and `init_done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock, at most 50 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| two_ranks | input | 1 | 1 when a second rank is fitted |
| dll_locked | input | 1 | PHY DLL lock indication |
| mrr_valid | input | 1 | One-cycle strobe: MRR result available |
| mrr_dai_busy | input | 1 | DAI status with the result: 1 means initialization is still running |
| cke | output | 1 | Clock enable to the memory |
| rank_idx | output | 1 | Rank addressed by the current command |
| cmd | output | 2 | 00 idle, 01 NOP, 10 MRS (reset/program), 11 MRR |
| dll_start | output | 1 | Enable for the PHY DLL, held high |
| dll_resync | output | 1 | One-cycle strobe to take up the DLL delay |
| aref_en | output | 1 | Auto-refresh enable |
| pd_en | output | 1 | Power-down enable |
| init_done | output | 1 | All configured ranks initialized |
| init_err | output | 1 | Lock or DAI timeout occurred |

## Verification
The bench keeps CLK_MHZ=50 and T_CKE_NS=100, which gives a five-cycle CKE-low interval. It shortens T_INIT_NS to 4000 ns (200 cycles) and keeps T_MRW_NS at 1000 ns (50 cycles), so that many full one- and two-rank sequences with varied lock delays, poll counts and read latencies fit in the run. TMO_CYC is set to 64, which is long enough for every legal poll pattern used, yet short enough to reach both the lock timeout and the DAI timeout within a few hundred cycles.

// File: rtl/lpddr_init_pkg.sv
package lpddr_init_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_NOP  = 2'd1,
    CMD_MRS  = 2'd2,
    CMD_MRR  = 2'd3
  } mem_cmd_e;

  typedef enum logic [3:0] {
    ST_LOCK,
    ST_RESYNC,
    ST_CKE_WAIT,
    ST_NOP,
    ST_T_INIT,
    ST_MRS,
    ST_T_MRW,
    ST_MRR,
    ST_MRR_WAIT,
    ST_DONE,
    ST_ERR
  } seq_state_e;

  // Cycles covering a time interval: ceil(ns * MHz / 1000), at least 1.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/lpddr_init_dcnt.sv
module lpddr_init_dcnt #(
  parameter int unsigned     W       = 8,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load | (dec & ~zero);

  always_comb begin
    cnt_d = cnt_q - 1'b1;
    if (load) cnt_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RST_VAL;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/lpddr_init_ctl.sv
module lpddr_init_ctl
  import lpddr_init_pkg::*;
#(
  parameter int unsigned CNT_W         = 8,
  parameter int unsigned CKE_CYC       = 5,
  parameter int unsigned INIT_CYC      = 100,
  parameter int unsigned MRW_CYC       = 50,
  parameter bit          PD_AFTER_INIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             two_ranks,
  input  logic             dll_locked,
  input  logic             mrr_valid,
  input  logic             mrr_dai_busy,
  input  logic             wait_zero,
  input  logic             tmo_zero,
  output logic             wait_load,
  output logic [CNT_W-1:0] wait_val,
  output logic             wait_dec,
  output logic             tmo_load,
  output logic             tmo_dec,
  output mem_cmd_e         cmd,
  output logic             cke,
  output logic             rank_idx,
  output logic             dll_start,
  output logic             dll_resync,
  output logic             aref_en,
  output logic             pd_en,
  output logic             done,
  output logic             err
);

  localparam logic [CNT_W-1:0] CKE_LD  = CNT_W'(CKE_CYC - 1);
  localparam logic [CNT_W-1:0] INIT_LD = CNT_W'(INIT_CYC - 1);
  localparam logic [CNT_W-1:0] MRW_LD  = CNT_W'(MRW_CYC - 1);

  seq_state_e state_q, state_d;
  logic       rank_q, rank_d;
  logic       cke_q;
  logic       dll_on_q;
  logic       last_rank;

  assign last_rank = ~two_ranks | rank_q;

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    rank_d    = rank_q;
    wait_load = 1'b0;
    wait_val  = '0;
    tmo_load  = 1'b0;
    unique case (state_q)
      ST_LOCK: begin
        if (dll_on_q && dll_locked) state_d = ST_RESYNC;
        else if (dll_on_q && tmo_zero) state_d = ST_ERR;
      end
      ST_RESYNC: begin
        state_d   = ST_CKE_WAIT;
        wait_load = 1'b1;
        wait_val  = CKE_LD;
      end
      ST_CKE_WAIT: if (wait_zero) state_d = ST_NOP;
      ST_NOP: begin
        state_d   = ST_T_INIT;
        wait_load = 1'b1;
        wait_val  = INIT_LD;
      end
      ST_T_INIT: if (wait_zero) state_d = ST_MRS;
      ST_MRS: begin
        state_d   = ST_T_MRW;
        wait_load = 1'b1;
        wait_val  = MRW_LD;
      end
      ST_T_MRW: begin
        if (wait_zero) begin
          state_d  = ST_MRR;
          tmo_load = 1'b1;
        end
      end
      ST_MRR: state_d = tmo_zero ? ST_ERR : ST_MRR_WAIT;
      ST_MRR_WAIT: begin
        if (mrr_valid && !mrr_dai_busy) begin
          if (last_rank) state_d = ST_DONE;
          else begin
            rank_d  = 1'b1;
            state_d = ST_NOP;
          end
        end else if (mrr_valid) state_d = ST_MRR;
        else if (tmo_zero)      state_d = ST_ERR;
      end
      ST_DONE: state_d = ST_DONE;
      ST_ERR:  state_d = ST_ERR;
      default: state_d = ST_ERR;
    endcase
  end

  assign wait_dec = (state_q == ST_CKE_WAIT) | (state_q == ST_T_INIT) | (state_q == ST_T_MRW);
  assign tmo_dec  = (dll_on_q & (state_q == ST_LOCK)) | (state_q == ST_MRR) | (state_q == ST_MRR_WAIT);

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOCK;
      rank_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rank_q  <= rank_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cke_q <= 1'b0;
    else if (state_q == ST_NOP)  cke_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dll_on_q <= 1'b0;
    else if (!dll_on_q) dll_on_q <= 1'b1;
  end

  // Output decode
  always_comb begin
    unique case (state_q)
      ST_NOP:  cmd = CMD_NOP;
      ST_MRS:  cmd = CMD_MRS;
      ST_MRR:  cmd = CMD_MRR;
      default: cmd = CMD_IDLE;
    endcase
  end

  assign cke        = cke_q | (state_q == ST_NOP);
  assign rank_idx   = rank_q;
  assign dll_start  = dll_on_q;
  assign dll_resync = (state_q == ST_RESYNC);
  assign done       = (state_q == ST_DONE);
  assign err        = (state_q == ST_ERR);
  assign aref_en    = done;
  assign pd_en      = done & PD_AFTER_INIT;

endmodule

// File: rtl/lpddr_init_seq.sv
module lpddr_init_seq
  import lpddr_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ       = 50,
  parameter int unsigned T_CKE_NS      = 100,
  parameter int unsigned T_INIT_NS     = 200000,
  parameter int unsigned T_MRW_NS      = 1000,
  parameter int unsigned TMO_CYC       = 4096,
  parameter bit          PD_AFTER_INIT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       two_ranks,
  input  logic       dll_locked,
  input  logic       mrr_valid,
  input  logic       mrr_dai_busy,
  output logic       cke,
  output logic       rank_idx,
  output logic [1:0] cmd,
  output logic       dll_start,
  output logic       dll_resync,
  output logic       aref_en,
  output logic       pd_en,
  output logic       init_done,
  output logic       init_err
);

  localparam int unsigned CKE_CYC  = ns_to_cyc(T_CKE_NS, CLK_MHZ);
  localparam int unsigned INIT_CYC = ns_to_cyc(T_INIT_NS, CLK_MHZ);
  localparam int unsigned MRW_CYC  = ns_to_cyc(T_MRW_NS, CLK_MHZ);
  localparam int unsigned MAX_CYC  = (INIT_CYC > CKE_CYC)
                                     ? ((INIT_CYC > MRW_CYC) ? INIT_CYC : MRW_CYC)
                                     : ((CKE_CYC > MRW_CYC) ? CKE_CYC : MRW_CYC);
  localparam int unsigned CNT_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam int unsigned TMO_W    = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
  localparam logic [TMO_W-1:0] TMO_LD = TMO_W'(TMO_CYC - 1);

  generate
    if (CLK_MHZ == 0 || CLK_MHZ > 50) begin : g_bad_clk
      $error("lpddr_init_seq: CLK_MHZ must be in 1..50");
    end
  endgenerate

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             wait_load, wait_dec, wait_zero;
  logic [CNT_W-1:0] wait_val;
  logic             tmo_load, tmo_dec, tmo_zero;
  mem_cmd_e         cmd_e;

  lpddr_init_dcnt #(.W(CNT_W), .RST_VAL('0)) u_wait (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (wait_load),
    .load_val (wait_val),
    .dec      (wait_dec),
    .zero     (wait_zero)
  );

  lpddr_init_dcnt #(.W(TMO_W), .RST_VAL(TMO_LD)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmo_load),
    .load_val (TMO_LD),
    .dec      (tmo_dec),
    .zero     (tmo_zero)
  );

  lpddr_init_ctl #(
    .CNT_W         (CNT_W),
    .CKE_CYC       (CKE_CYC),
    .INIT_CYC      (INIT_CYC),
    .MRW_CYC       (MRW_CYC),
    .PD_AFTER_INIT (PD_AFTER_INIT)
  ) u_ctl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .two_ranks    (two_ranks),
    .dll_locked   (dll_locked),
    .mrr_valid    (mrr_valid),
    .mrr_dai_busy (mrr_dai_busy),
    .wait_zero    (wait_zero),
    .tmo_zero     (tmo_zero),
    .wait_load    (wait_load),
    .wait_val     (wait_val),
    .wait_dec     (wait_dec),
    .tmo_load     (tmo_load),
    .tmo_dec      (tmo_dec),
    .cmd          (cmd_e),
    .cke          (cke),
    .rank_idx     (rank_idx),
    .dll_start    (dll_start),
    .dll_resync   (dll_resync),
    .aref_en      (aref_en),
    .pd_en        (pd_en),
    .done         (init_done),
    .err          (init_err)
  );

  assign cmd = cmd_e;

endmodule

// File: rtl/lpddr_init_seq_chk.sv
module lpddr_init_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic [1:0] cmd,
  input logic       dll_resync,
  input logic       aref_en,
  input logic       pd_en,
  input logic       init_done,
  input logic       init_err
);

  // R4: CKE never falls once raised
  a_r4_cke_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  // R4: no command while CKE is low
  a_r4_cmd_needs_cke: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 2'b00) |-> cke);

  // R3: resync strobe lasts one cycle
  a_r3_resync_single: assert property (@(posedge clk) disable iff (!rst_n)
    dll_resync |=> !dll_resync);

  // R3: resync happens before CKE rises
  a_r3_resync_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    dll_resync |-> !cke);

  // R5: MRS is followed by an idle cycle
  a_r5_mrs_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b10) |=> (cmd == 2'b00));

  // R9: refresh and power-down only after completion
  a_r9_aref_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    aref_en |-> init_done);
  a_r9_pd_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    pd_en |-> init_done);

  // R9: completion is sticky
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R10: error excludes completion and is sticky
  a_r10_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    init_err |-> !init_done);
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_err |=> (init_err && cmd == 2'b00));

endmodule

bind lpddr_init_seq lpddr_init_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cke        (cke),
  .cmd        (cmd),
  .dll_resync (dll_resync),
  .aref_en    (aref_en),
  .pd_en      (pd_en),
  .init_done  (init_done),
  .init_err   (init_err)
);

// File: tb/lpddr_init_seq_bench.sv
module lpddr_init_seq_bench;

  localparam int MHZ     = 50;
  localparam int CKE_NS  = 100;
  localparam int INIT_NS = 4000;
  localparam int MRW_NS  = 1000;
  localparam int TMO     = 64;

  function automatic int cyc_of(input int ns);
    return (ns * MHZ + 999) / 1000;
  endfunction

  localparam int CKE_C  = (CKE_NS * MHZ + 999) / 1000;
  localparam int INIT_C = (INIT_NS * MHZ + 999) / 1000;
  localparam int MRW_C  = (MRW_NS * MHZ + 999) / 1000;

  logic clk = 1'b0;
  logic rst_n, two_ranks, dll_locked, mrr_valid, mrr_dai_busy;
  logic cke, rank_idx, dll_start, dll_resync, aref_en, pd_en, init_done, init_err;
  logic [1:0] cmd;

  always #10 clk = ~clk;

  lpddr_init_seq #(
    .CLK_MHZ(MHZ), .T_CKE_NS(CKE_NS), .T_INIT_NS(INIT_NS), .T_MRW_NS(MRW_NS),
    .TMO_CYC(TMO), .PD_AFTER_INIT(1'b1)
  ) u_lpddr_init_seq (
    .clk(clk), .rst_n(rst_n), .two_ranks(two_ranks), .dll_locked(dll_locked),
    .mrr_valid(mrr_valid), .mrr_dai_busy(mrr_dai_busy), .cke(cke), .rank_idx(rank_idx),
    .cmd(cmd), .dll_start(dll_start), .dll_resync(dll_resync), .aref_en(aref_en),
    .pd_en(pd_en), .init_done(init_done), .init_err(init_err)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Per-trial observations
  int resync_n, resync_cyc, cke_rise, nop_n, done_cyc, err_cyc;
  int nop_cyc[2], nop_rank[2], mrs_cyc[2], mrr_first[2], mrr_n[2], ok_resp[2];
  bit cke_drop, cmd_wo_cke, start_low, early_en, rank_bad, cmd_after_err, any_cmd;

  // mode: 0 normal, 1 lock never comes, 2 DAI always busy
  task automatic run_trial(input bit two, input int lock_at, input int busy0,
                           input int busy1, input int lat, input int mode);
    int pend, busy_left, r;
    rst_n = 1'b0; two_ranks = two; dll_locked = 1'b0; mrr_valid = 1'b0; mrr_dai_busy = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cke == 0 && cmd == 2'b00 && !dll_start && !dll_resync, "R1 cke/cmd/dll", {cke, cmd, dll_start, dll_resync}, 0);
    chk(!aref_en && !pd_en && !init_done && !init_err, "R1 status", {aref_en, pd_en, init_done, init_err}, 0);
    resync_n = 0; resync_cyc = -1; cke_rise = -1; nop_n = 0; done_cyc = -1; err_cyc = -1;
    for (int i = 0; i < 2; i++) begin
      nop_cyc[i] = -1; nop_rank[i] = -1; mrs_cyc[i] = -1; mrr_first[i] = -1; mrr_n[i] = 0; ok_resp[i] = -1;
    end
    cke_drop = 0; cmd_wo_cke = 0; start_low = 0; early_en = 0; rank_bad = 0; cmd_after_err = 0; any_cmd = 0;
    pend = 0; busy_left = busy0;
    rst_n = 1'b1;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      r = (nop_n > 1) ? 1 : 0;
      dll_locked = (lock_at >= 0 && c >= lock_at);
      mrr_valid = 1'b0; mrr_dai_busy = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mrr_valid = 1'b1;
          if (busy_left > 0) begin mrr_dai_busy = 1'b1; busy_left--; end
          else ok_resp[r] = c;
        end
      end
      if (err_cyc >= 0 && cmd != 2'b00) cmd_after_err = 1;
      if (cmd != 2'b00) any_cmd = 1;
      if (cmd == 2'b11) pend = lat;
      if (dll_resync) begin resync_n++; if (resync_cyc < 0) resync_cyc = c; end
      if (cke && cke_rise < 0) cke_rise = c;
      if (!cke && cke_rise >= 0) cke_drop = 1;
      if (cmd != 2'b00 && !cke) cmd_wo_cke = 1;
      if (c >= 2 && !dll_start) start_low = 1;
      if ((aref_en || pd_en) && !init_done) early_en = 1;
      if (cmd == 2'b01) begin
        if (nop_n < 2) begin nop_cyc[nop_n] = c; nop_rank[nop_n] = rank_idx; end
        nop_n++;
        if (nop_n == 2) busy_left = busy1;
        r = (nop_n > 1) ? 1 : 0;
      end
      if (cmd == 2'b10) begin mrs_cyc[r] = c; if (rank_idx != r[0]) rank_bad = 1; end
      if (cmd == 2'b11) begin
        if (mrr_n[r] == 0) mrr_first[r] = c;
        mrr_n[r]++;
        if (rank_idx != r[0]) rank_bad = 1;
      end
      if (init_done && done_cyc < 0) done_cyc = c;
      if (init_err && err_cyc < 0) err_cyc = c;
      if (done_cyc >= 0 && c >= done_cyc + 4) break;
      if (err_cyc >= 0 && c >= err_cyc + 4) break;
    end

    if (mode == 0) begin
      chk(!start_low, "R2 dll_start held", start_low, 0);
      chk(err_cyc < 0, "R2 no error", err_cyc, -1);
      chk(resync_n == 1, "R3 resync pulse count", resync_n, 1);
      chk(resync_cyc == lock_at + 1, "R3 resync cycle", resync_cyc, lock_at + 1);
      chk(nop_cyc[0] == resync_cyc + CKE_C + 1, "R4 first NOP cycle", nop_cyc[0], resync_cyc + CKE_C + 1);
      chk(cke_rise == nop_cyc[0] && !cke_drop && !cmd_wo_cke, "R4 cke rise/hold", cke_rise, nop_cyc[0]);
      for (int k = 0; k < (two ? 2 : 1); k++) begin
        chk(mrs_cyc[k] - nop_cyc[k] == INIT_C + 1, "R5 NOP to MRS", mrs_cyc[k] - nop_cyc[k], INIT_C + 1);
        chk(mrr_first[k] - mrs_cyc[k] == MRW_C + 1, "R6 MRS to MRR", mrr_first[k] - mrs_cyc[k], MRW_C + 1);
        chk(mrr_n[k] == ((k == 0) ? busy0 : busy1) + 1, "R7 MRR count", mrr_n[k], ((k == 0) ? busy0 : busy1) + 1);
        chk(nop_rank[k] == k, "R8 rank at NOP", nop_rank[k], k);
      end
      chk(nop_n == (two ? 2 : 1), "R8 NOP count", nop_n, two ? 2 : 1);
      chk(!rank_bad, "R8 rank_idx on commands", rank_bad, 0);
      if (two) chk(nop_cyc[1] == ok_resp[0] + 1, "R8 rank1 start", nop_cyc[1], ok_resp[0] + 1);
      chk(!early_en, "R9 enables before done", early_en, 0);
      chk(done_cyc == ok_resp[two ? 1 : 0] + 1, "R9 done cycle", done_cyc, ok_resp[two ? 1 : 0] + 1);
      chk(aref_en && pd_en, "R9 enables after done", {aref_en, pd_en}, 3);
    end else if (mode == 1) begin
      chk(err_cyc >= 0 && err_cyc <= TMO + 4, "R10 lock timeout", err_cyc, TMO + 4);
      chk(cke_rise < 0 && !any_cmd, "R10 no cke/cmd", cke_rise, -1);
      chk(done_cyc < 0 && !early_en, "R10 no done", done_cyc, -1);
    end else begin
      chk(err_cyc - mrr_first[0] == TMO || err_cyc - mrr_first[0] == TMO + 1,
          "R11 DAI timeout", err_cyc - mrr_first[0], TMO);
      chk(done_cyc < 0 && !cmd_after_err, "R11 stop after err", done_cyc, -1);
      chk(!aref_en && !pd_en, "R11 enables off", {aref_en, pd_en}, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    chk(cyc_of(INIT_NS) == INIT_C, "R5 bench timing", cyc_of(INIT_NS), INIT_C);
    // Directed corners
    run_trial(1'b0, 3, 0, 0, 1, 0);
    run_trial(1'b1, 10, 2, 1, 3, 0);
    run_trial(1'b1, 3, 0, 0, 1, 0);
    // Random mixes
    for (int t = 0; t < 6; t++) begin
      run_trial(1'($urandom_range(0, 1)), int'($urandom_range(3, 20)),
                int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                int'($urandom_range(1, 3)), 0);
    end
    // Timeouts
    run_trial(1'b0, -1, 0, 0, 1, 1);
    run_trial(1'b1, 5, 1000000, 0, 2, 2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule